// File: doc/BRIEF.md
# Paired-Pin AXI Channel Slice

This block sits at the edge of an AXI3 slave port where the payload of every channel crosses the package on half as many pins as it has bits. Each pin carries two bits per clock period. The first bit is driven while the clock is high and is captured on the falling edge. The second bit is driven while the clock is low and is captured on the following rising edge. On the three inbound channels (write address, write data, read address), the block captures both phases and rebuilds the full-width beat. On the two outbound channels (read data, write response), it takes a full-width beat from the core side and drives it back onto paired pins in the same two-phase form.

The capture registers also serve as a one-deep register slice, so every channel adds exactly one clock of latency. VALID and READY are never paired: they travel on their own wires. The upstream READY of each channel follows the downstream READY combinationally, which lets a full-rate stream pass without bubbles. The core side sees flat payload vectors. The bit layout of those vectors and the pin pairing are fixed by the requirements below.

Top module: `pairpin_axi_slice`

## Requirements
- R1: While reset is low, and afterwards until the first beat is loaded, every downstream VALID (awOutValid, wOutValid, arOutValid, rValid, bValid) is 0. The outbound pins rPins and bPins are 0 in both phases. Each upstream READY is 1.
- R2: On the address channels (aw, ar, 32 pins), pins 0 to 15 carry address bit k first and bit k+16 second. Pins 16 to 22 carry ID bit 2j first and bit 2j+1 second. Pin 23 carries ID bit 14 first and PROT bit 2 second. Pins 24 and 25 carry LEN bit j first and bit j+2 second. Pins 26, 27 and 28 carry bit 0 first and bit 1 second of SIZE, BURST and LOCK respectively. Pins 29 and 30 carry CACHE bit j first and bit j+2 second. Pin 31 carries PROT bit 0 first and bit 1 second. The rebuilt beat is {addr[31:0], id[14:0], len[3:0], size[1:0], burst[1:0], lock[1:0], cache[3:0], prot[2:0]}, most significant field first.
- R3: On the write-data channel (44 pins), pins 0 to 31 carry data bit k first and bit k+32 second. Pins 32 to 38 carry ID bit 2j first and bit 2j+1 second. Pin 39 carries ID bit 14 first and LAST second. Pins 40 to 43 carry strobe bit j first and bit j+4 second. The rebuilt beat is {data[63:0], id[14:0], strb[7:0], last}.
- R4: The read-data input beat is {data[63:0], id[14:0], resp[1:0], last}. It is driven on 41 pins with the same data and ID pairing as R3. Pin 39 carries ID bit 14 first and LAST second. Pin 40 carries RESP bit 0 first and bit 1 second. The first phase appears while the clock is high and the second while it is low.
- R5: The write-response input beat is {id[14:0], resp[1:0]}. It is driven on 9 pins. Pins 0 to 6 carry ID bit 2j first and bit 2j+1 second. Pin 7 carries ID bit 14 first and a constant 0 second. Pin 8 carries RESP bit 0 first and bit 1 second.
- R6: A beat accepted at a rising edge (VALID and READY both 1) is presented, with its downstream VALID at 1, directly after that same edge. This is one cycle of latency.
- R7: Each upstream READY equals 1 whenever the slice is empty or the downstream READY is 1. With both sides always willing, one beat passes per cycle. With nothing offered and the downstream ready, the slice empties.
- R8: While a downstream VALID is 1 and its READY is 0, the VALID and the payload stay unchanged. No beat is lost, duplicated or reordered on any channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges used for capture |
| rstN | input | 1 | Asynchronous active-low reset |
| awPins | input | 32 | Paired write-address payload pins |
| awValid | input | 1 | Write-address VALID from the link |
| awReady | output | 1 | Write-address READY to the link |
| awOutBeat | output | 64 | Rebuilt write-address beat |
| awOutValid | output | 1 | Write-address VALID to the core |
| awOutReady | input | 1 | Write-address READY from the core |
| wPins | input | 44 | Paired write-data payload pins |
| wValid | input | 1 | Write-data VALID from the link |
| wReady | output | 1 | Write-data READY to the link |
| wOutBeat | output | 88 | Rebuilt write-data beat |
| wOutValid | output | 1 | Write-data VALID to the core |
| wOutReady | input | 1 | Write-data READY from the core |
| arPins | input | 32 | Paired read-address payload pins |
| arValid | input | 1 | Read-address VALID from the link |
| arReady | output | 1 | Read-address READY to the link |
| arOutBeat | output | 64 | Rebuilt read-address beat |
| arOutValid | output | 1 | Read-address VALID to the core |
| arOutReady | input | 1 | Read-address READY from the core |
| rInBeat | input | 82 | Read-data beat from the core |
| rInValid | input | 1 | Read-data VALID from the core |
| rInReady | output | 1 | Read-data READY to the core |
| rPins | output | 41 | Paired read-data payload pins |
| rValid | output | 1 | Read-data VALID to the link |
| rReady | input | 1 | Read-data READY from the link |
| bInBeat | input | 17 | Write-response beat from the core |
| bInValid | input | 1 | Write-response VALID from the core |
| bInReady | output | 1 | Write-response READY to the core |
| bPins | output | 9 | Paired write-response payload pins |
| bValid | output | 1 | Write-response VALID to the link |
| bReady | input | 1 | Write-response READY from the link |

## Verification
The first beats on every channel are all-ones and alternating-bit patterns. These show a swapped phase or a crossed pin pair, which random data can hide when bits happen to agree. A stretch with VALID and READY held high on both sides shows whether the slice sustains one beat per cycle or inserts bubbles. Random VALID and READY after that exercise the fill, stall and drain orderings. A long full stall followed by a drain shows whether a held beat is kept, lost or repeated.

// File: rtl/pairpin_pkg.sv
package pairpin_pkg;

  localparam int DATA_W  = 64;
  localparam int ADDR_W  = 32;
  localparam int ID_W    = 15;
  localparam int LEN_W   = 4;
  localparam int CACHE_W = 4;
  localparam int STRB_W  = DATA_W / 8;

  localparam int DATA_PAIRS = DATA_W / 2;
  localparam int ADDR_PAIRS = ADDR_W / 2;
  localparam int ID_PAIRS   = (ID_W - 1) / 2;

  localparam int ADDR_PINS = ADDR_PAIRS + ID_PAIRS + 1 + LEN_W / 2 + 3 + CACHE_W / 2 + 1;
  localparam int WR_PINS   = DATA_PAIRS + ID_PAIRS + 1 + STRB_W / 2;
  localparam int RD_PINS   = DATA_PAIRS + ID_PAIRS + 2;
  localparam int RESP_PINS = ID_PAIRS + 2;

  typedef struct packed {
    logic [ADDR_W-1:0]  addr;
    logic [ID_W-1:0]    id;
    logic [LEN_W-1:0]   len;
    logic [1:0]         size;
    logic [1:0]         burst;
    logic [1:0]         lock;
    logic [CACHE_W-1:0] cache;
    logic [2:0]         prot;
  } addrBeatT;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [ID_W-1:0]   id;
    logic [STRB_W-1:0] strb;
    logic              last;
  } wrBeatT;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [ID_W-1:0]   id;
    logic [1:0]        resp;
    logic              last;
  } rdBeatT;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic [1:0]      resp;
  } respBeatT;

  localparam int ADDR_BEAT_W = $bits(addrBeatT);
  localparam int WR_BEAT_W   = $bits(wrBeatT);
  localparam int RD_BEAT_W   = $bits(rdBeatT);
  localparam int RESP_BEAT_W = $bits(respBeatT);

  // strobes from a channel's handshake control to its datapath
  typedef struct packed {
    logic load;
  } sliceStrobeT;

  // phase vectors: [PINS-1:0] = first phase (clock high), upper half = second phase
  function automatic addrBeatT joinAddr(logic [2*ADDR_PINS-1:0] v);
    addrBeatT b;
    logic [ADDR_PINS-1:0] f, s;
    int p;
    b = '0;
    f = v[ADDR_PINS-1:0];
    s = v[2*ADDR_PINS-1:ADDR_PINS];
    p = 0;
    for (int k = 0; k < ADDR_PAIRS; k++) begin
      b.addr[k] = f[p]; b.addr[k+ADDR_PAIRS] = s[p]; p++;
    end
    for (int j = 0; j < ID_PAIRS; j++) begin
      b.id[2*j] = f[p]; b.id[2*j+1] = s[p]; p++;
    end
    b.id[ID_W-1] = f[p]; b.prot[2] = s[p]; p++;
    for (int j = 0; j < LEN_W / 2; j++) begin
      b.len[j] = f[p]; b.len[j+LEN_W/2] = s[p]; p++;
    end
    b.size[0]  = f[p]; b.size[1]  = s[p]; p++;
    b.burst[0] = f[p]; b.burst[1] = s[p]; p++;
    b.lock[0]  = f[p]; b.lock[1]  = s[p]; p++;
    for (int j = 0; j < CACHE_W / 2; j++) begin
      b.cache[j] = f[p]; b.cache[j+CACHE_W/2] = s[p]; p++;
    end
    b.prot[0] = f[p]; b.prot[1] = s[p];
    return b;
  endfunction

  function automatic wrBeatT joinWr(logic [2*WR_PINS-1:0] v);
    wrBeatT b;
    logic [WR_PINS-1:0] f, s;
    int p;
    b = '0;
    f = v[WR_PINS-1:0];
    s = v[2*WR_PINS-1:WR_PINS];
    p = 0;
    for (int k = 0; k < DATA_PAIRS; k++) begin
      b.data[k] = f[p]; b.data[k+DATA_PAIRS] = s[p]; p++;
    end
    for (int j = 0; j < ID_PAIRS; j++) begin
      b.id[2*j] = f[p]; b.id[2*j+1] = s[p]; p++;
    end
    b.id[ID_W-1] = f[p]; b.last = s[p]; p++;
    for (int j = 0; j < STRB_W / 2; j++) begin
      b.strb[j] = f[p]; b.strb[j+STRB_W/2] = s[p]; p++;
    end
    return b;
  endfunction

  function automatic logic [2*RD_PINS-1:0] splitRd(rdBeatT b);
    logic [RD_PINS-1:0] f, s;
    int p;
    p = 0;
    for (int k = 0; k < DATA_PAIRS; k++) begin
      f[p] = b.data[k]; s[p] = b.data[k+DATA_PAIRS]; p++;
    end
    for (int j = 0; j < ID_PAIRS; j++) begin
      f[p] = b.id[2*j]; s[p] = b.id[2*j+1]; p++;
    end
    f[p] = b.id[ID_W-1]; s[p] = b.last; p++;
    f[p] = b.resp[0];    s[p] = b.resp[1];
    return {s, f};
  endfunction

  function automatic logic [2*RESP_PINS-1:0] splitResp(respBeatT b);
    logic [RESP_PINS-1:0] f, s;
    int p;
    p = 0;
    for (int j = 0; j < ID_PAIRS; j++) begin
      f[p] = b.id[2*j]; s[p] = b.id[2*j+1]; p++;
    end
    f[p] = b.id[ID_W-1]; s[p] = 1'b0; p++;
    f[p] = b.resp[0];    s[p] = b.resp[1];
    return {s, f};
  endfunction

endpackage

// File: rtl/pairpin_ctrl.sv
module pairpin_ctrl
  import pairpin_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        upValid,
  output logic        upReady,
  output logic        dnValid,
  input  logic        dnReady,
  output sliceStrobeT strobe
);

  assign upReady     = !dnValid || dnReady;
  assign strobe.load = upValid && upReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        dnValid <= 1'b0;
    else if (upReady) dnValid <= upValid;
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    dnValid && !dnReady |=> dnValid);

  // R6
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    upValid && upReady |=> dnValid);

  // R7
  drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    !upValid && dnReady |=> !dnValid);

endmodule

// File: rtl/pairpin_rx_path.sv
module pairpin_rx_path
  import pairpin_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PINS-1:0]   pinsIn,
  input  sliceStrobeT       strobe,
  output logic [2*PINS-1:0] phasesOut
);

  logic [PINS-1:0] firstCapt;

  // first phase is valid while the clock is high: take it on the falling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) firstCapt <= '0;
    else       firstCapt <= pinsIn;
  end

  // second phase sits on the pins at the rising edge; both halves load together
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            phasesOut <= '0;
    else if (strobe.load) phasesOut <= {pinsIn, firstCapt};
  end

endmodule

// File: rtl/pairpin_tx_path.sv
module pairpin_tx_path
  import pairpin_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2*PINS-1:0] phasesIn,
  input  sliceStrobeT       strobe,
  output logic [PINS-1:0]   pinsOut
);

  logic [2*PINS-1:0] hold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            hold <= '0;
    else if (strobe.load) hold <= phasesIn;
  end

  // first half while the clock is high, second half while it is low
  assign pinsOut = clk ? hold[PINS-1:0] : hold[2*PINS-1:PINS];

endmodule

// File: rtl/pairpin_axi_slice.sv
module pairpin_axi_slice
  import pairpin_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_PINS-1:0]   awPins,
  input  logic                   awValid,
  output logic                   awReady,
  output logic [ADDR_BEAT_W-1:0] awOutBeat,
  output logic                   awOutValid,
  input  logic                   awOutReady,
  input  logic [WR_PINS-1:0]     wPins,
  input  logic                   wValid,
  output logic                   wReady,
  output logic [WR_BEAT_W-1:0]   wOutBeat,
  output logic                   wOutValid,
  input  logic                   wOutReady,
  input  logic [ADDR_PINS-1:0]   arPins,
  input  logic                   arValid,
  output logic                   arReady,
  output logic [ADDR_BEAT_W-1:0] arOutBeat,
  output logic                   arOutValid,
  input  logic                   arOutReady,
  input  logic [RD_BEAT_W-1:0]   rInBeat,
  input  logic                   rInValid,
  output logic                   rInReady,
  output logic [RD_PINS-1:0]     rPins,
  output logic                   rValid,
  input  logic                   rReady,
  input  logic [RESP_BEAT_W-1:0] bInBeat,
  input  logic                   bInValid,
  output logic                   bInReady,
  output logic [RESP_PINS-1:0]   bPins,
  output logic                   bValid,
  input  logic                   bReady
);

  sliceStrobeT awStb, wStb, arStb, rStb, bStb;
  logic [2*ADDR_PINS-1:0] awPhases, arPhases;
  logic [2*WR_PINS-1:0]   wPhases;
  logic [2*RD_PINS-1:0]   rPhases;
  logic [2*RESP_PINS-1:0] bPhases;

  // write address
  pairpin_ctrl awCtrl (.clk(clk), .rstN(rstN), .upValid(awValid), .upReady(awReady),
                       .dnValid(awOutValid), .dnReady(awOutReady), .strobe(awStb));
  pairpin_rx_path #(.PINS(ADDR_PINS)) awPath (.clk(clk), .rstN(rstN), .pinsIn(awPins),
                       .strobe(awStb), .phasesOut(awPhases));
  assign awOutBeat = joinAddr(awPhases);

  // write data
  pairpin_ctrl wCtrl (.clk(clk), .rstN(rstN), .upValid(wValid), .upReady(wReady),
                      .dnValid(wOutValid), .dnReady(wOutReady), .strobe(wStb));
  pairpin_rx_path #(.PINS(WR_PINS)) wPath (.clk(clk), .rstN(rstN), .pinsIn(wPins),
                      .strobe(wStb), .phasesOut(wPhases));
  assign wOutBeat = joinWr(wPhases);

  // read address
  pairpin_ctrl arCtrl (.clk(clk), .rstN(rstN), .upValid(arValid), .upReady(arReady),
                       .dnValid(arOutValid), .dnReady(arOutReady), .strobe(arStb));
  pairpin_rx_path #(.PINS(ADDR_PINS)) arPath (.clk(clk), .rstN(rstN), .pinsIn(arPins),
                       .strobe(arStb), .phasesOut(arPhases));
  assign arOutBeat = joinAddr(arPhases);

  // read data
  assign rPhases = splitRd(rInBeat);
  pairpin_ctrl rCtrl (.clk(clk), .rstN(rstN), .upValid(rInValid), .upReady(rInReady),
                      .dnValid(rValid), .dnReady(rReady), .strobe(rStb));
  pairpin_tx_path #(.PINS(RD_PINS)) rPath (.clk(clk), .rstN(rstN), .phasesIn(rPhases),
                      .strobe(rStb), .pinsOut(rPins));

  // write response
  assign bPhases = splitResp(bInBeat);
  pairpin_ctrl bCtrl (.clk(clk), .rstN(rstN), .upValid(bInValid), .upReady(bInReady),
                      .dnValid(bValid), .dnReady(bReady), .strobe(bStb));
  pairpin_tx_path #(.PINS(RESP_PINS)) bPath (.clk(clk), .rstN(rstN), .phasesIn(bPhases),
                      .strobe(bStb), .pinsOut(bPins));

  // R8
  aw_payload_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    awOutValid && !awOutReady |=> $stable(awOutBeat));

  // R8
  w_payload_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wOutValid && !wOutReady |=> $stable(wOutBeat));

  // R8
  ar_payload_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    arOutValid && !arOutReady |=> $stable(arOutBeat));

endmodule

// File: tb/pairpin_axi_slice_tb.sv
module pairpin_axi_slice_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  always #10 clk = ~clk;

  logic [31:0] awPins, arPins;
  logic [43:0] wPins;
  logic awValid, wValid, arValid, awOutReady, wOutReady, arOutReady;
  logic awReady, wReady, arReady, awOutValid, wOutValid, arOutValid;
  logic [63:0] awOutBeat, arOutBeat;
  logic [87:0] wOutBeat;
  logic [81:0] rInBeat;
  logic [16:0] bInBeat;
  logic rInValid, bInValid, rInReady, bInReady, rValid, bValid, rReady, bReady;
  logic [40:0] rPins;
  logic [8:0]  bPins;

  pairpin_axi_slice dut_i (
    .clk(clk), .rstN(rstN),
    .awPins(awPins), .awValid(awValid), .awReady(awReady), .awOutBeat(awOutBeat),
    .awOutValid(awOutValid), .awOutReady(awOutReady),
    .wPins(wPins), .wValid(wValid), .wReady(wReady), .wOutBeat(wOutBeat),
    .wOutValid(wOutValid), .wOutReady(wOutReady),
    .arPins(arPins), .arValid(arValid), .arReady(arReady), .arOutBeat(arOutBeat),
    .arOutValid(arOutValid), .arOutReady(arOutReady),
    .rInBeat(rInBeat), .rInValid(rInValid), .rInReady(rInReady), .rPins(rPins),
    .rValid(rValid), .rReady(rReady),
    .bInBeat(bInBeat), .bInValid(bInValid), .bInReady(bInReady), .bPins(bPins),
    .bValid(bValid), .bReady(bReady)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // channels: 0 aw, 1 w, 2 ar, 3 r, 4 b
  function automatic int beatW(int ch);
    case (ch) 0, 2: return 64; 1: return 88; 3: return 82; default: return 17; endcase
  endfunction
  function automatic int pinN(int ch);
    case (ch) 0, 2: return 32; 1: return 44; 3: return 41; default: return 9; endcase
  endfunction

  // flat beat bit carried by pin p in phase ph (0 first, 1 second); -1 = constant 0
  function automatic int src(int ch, int p, int ph);
    if (ch == 0 || ch == 2) begin
      if (p < 16) return 32 + p + 16 * ph;
      if (p < 23) return 17 + 2 * (p - 16) + ph;
      if (p == 23) return ph ? 2 : 31;
      if (p < 26) return 13 + (p - 24) + 2 * ph;
      if (p == 26) return 11 + ph;
      if (p == 27) return 9 + ph;
      if (p == 28) return 7 + ph;
      if (p < 31) return 3 + (p - 29) + 2 * ph;
      return ph;
    end else if (ch == 1) begin
      if (p < 32) return 24 + p + 32 * ph;
      if (p < 39) return 9 + 2 * (p - 32) + ph;
      if (p == 39) return ph ? 0 : 23;
      return 1 + (p - 40) + 4 * ph;
    end else if (ch == 3) begin
      if (p < 32) return 18 + p + 32 * ph;
      if (p < 39) return 3 + 2 * (p - 32) + ph;
      if (p == 39) return ph ? 0 : 17;
      return 1 + ph;
    end
    if (p < 7) return 2 + 2 * p + ph;
    if (p == 7) return ph ? -1 : 16;
    return ph;
  endfunction

  // result: first phase in [47:0], second phase in [95:48]
  function automatic logic [95:0] split(int ch, logic [95:0] beat);
    logic [95:0] r = '0;
    for (int p = 0; p < pinN(ch); p++)
      for (int ph = 0; ph < 2; ph++) begin
        int s = src(ch, p, ph);
        r[ph*48+p] = (s < 0) ? 1'b0 : beat[s];
      end
    return r;
  endfunction

  function automatic logic [95:0] join2(int ch, logic [47:0] f, logic [47:0] s2);
    logic [95:0] b = '0;
    for (int p = 0; p < pinN(ch); p++)
      for (int ph = 0; ph < 2; ph++) begin
        int s = src(ch, p, ph);
        if (s >= 0) b[s] = ph ? s2[p] : f[p];
      end
    return b;
  endfunction

  function automatic logic [95:0] gen(int ch, int idx);
    logic [95:0] m = (96'd1 << beatW(ch)) - 96'd1;
    if (idx == 0) return m;
    if (idx == 1) return {24{4'hA}} & m;
    if (idx == 2) return {24{4'h5}} & m;
    return {$urandom, $urandom, $urandom} & m;
  endfunction

  task automatic setRx(int ch, logic [47:0] pins, logic v, logic rdy);
    case (ch)
      0: begin awPins = pins[31:0]; awValid = v; awOutReady = rdy; end
      1: begin wPins = pins[43:0]; wValid = v; wOutReady = rdy; end
      default: begin arPins = pins[31:0]; arValid = v; arOutReady = rdy; end
    endcase
  endtask
  task automatic setRxPins(int ch, logic [47:0] pins);
    case (ch)
      0: awPins = pins[31:0];
      1: wPins = pins[43:0];
      default: arPins = pins[31:0];
    endcase
  endtask
  function automatic logic rxRdy(int ch);
    case (ch) 0: return awReady; 1: return wReady; default: return arReady; endcase
  endfunction
  function automatic logic outV(int ch);
    case (ch) 0: return awOutValid; 1: return wOutValid; default: return arOutValid; endcase
  endfunction
  function automatic logic [95:0] outB(int ch);
    case (ch) 0: return {32'd0, awOutBeat}; 1: return {8'd0, wOutBeat};
      default: return {32'd0, arOutBeat}; endcase
  endfunction

  task automatic setTx(int ch, logic [95:0] beat, logic v, logic rdy);
    if (ch == 3) begin rInBeat = beat[81:0]; rInValid = v; rReady = rdy; end
    else begin bInBeat = beat[16:0]; bInValid = v; bReady = rdy; end
  endtask
  function automatic logic txInRdy(int ch);
    return (ch == 3) ? rInReady : bInReady;
  endfunction
  function automatic logic txV(int ch);
    return (ch == 3) ? rValid : bValid;
  endfunction
  function automatic logic [47:0] txP(int ch);
    return (ch == 3) ? {7'd0, rPins} : {39'd0, bPins};
  endfunction

  logic [95:0] q0[$], q1[$], q2[$], q3[$], q4[$];
  task automatic qPush(int ch, logic [95:0] v);
    case (ch) 0: q0.push_back(v); 1: q1.push_back(v); 2: q2.push_back(v);
      3: q3.push_back(v); default: q4.push_back(v); endcase
  endtask
  task automatic qPop(int ch, output logic [95:0] v, output bit ok);
    ok = 1; v = '0;
    case (ch)
      0: if (q0.size() > 0) v = q0.pop_front(); else ok = 0;
      1: if (q1.size() > 0) v = q1.pop_front(); else ok = 0;
      2: if (q2.size() > 0) v = q2.pop_front(); else ok = 0;
      3: if (q3.size() > 0) v = q3.pop_front(); else ok = 0;
      default: if (q4.size() > 0) v = q4.pop_front(); else ok = 0;
    endcase
  endtask
  function automatic int qSize(int ch);
    case (ch) 0: return q0.size(); 1: return q1.size(); 2: return q2.size();
      3: return q3.size(); default: return q4.size(); endcase
  endfunction

  function automatic string mapReq(int ch);
    case (ch) 0, 2: return "R2"; 1: return "R3"; 3: return "R4"; default: return "R5"; endcase
  endfunction

  logic [95:0] cur[5], accBeat[5], prevOut[5];
  bit pend[5], justAcc[5], prevStall[5], txRdyB[5];
  int genCnt[5];
  logic [47:0] firstS[5];

  initial begin
    int vp, rp;
    logic [95:0] e, got;
    bit ok;
    void'($urandom(32'd7741));
    for (int c = 0; c < 3; c++) setRx(c, '0, 1'b0, 1'b0);
    for (int c = 3; c < 5; c++) setTx(c, '0, 1'b0, 1'b0);
    for (int c = 0; c < 5; c++) begin
      pend[c] = 0; justAcc[c] = 0; prevStall[c] = 0; genCnt[c] = 0; txRdyB[c] = 0;
    end
    #1 rstN = 1'b0;
    @(posedge clk); #5;
    // R1 reset state, first phase (clock high)
    for (int c = 0; c < 3; c++) begin
      chk("R1 out valid", outV(c), 0);
      chk("R1 upstream ready", rxRdy(c), 1);
    end
    for (int c = 3; c < 5; c++) begin
      chk("R1 link valid", txV(c), 0);
      chk("R1 pins first phase", txP(c), 0);
    end
    #10;
    for (int c = 3; c < 5; c++) chk("R1 pins second phase", txP(c), 0);
    @(posedge clk); #2 rstN = 1'b1;

    for (int n = 0; n < 2660; n++) begin
      if (n < 200)       begin vp = 100; rp = 100; end
      else if (n < 1600) begin vp = 50;  rp = 50;  end
      else if (n < 1700) begin vp = 100; rp = 0;   end
      else if (n < 2600) begin vp = 80;  rp = 70;  end
      else               begin vp = 0;   rp = 100; end
      @(posedge clk); #2;
      for (int c = 0; c < 5; c++) begin
        if (!pend[c] && ($urandom % 100) < vp) begin
          cur[c] = gen(c, genCnt[c]); genCnt[c]++; pend[c] = 1;
        end
        txRdyB[c] = (($urandom % 100) < rp);
        if (c < 3) setRx(c, split(c, cur[c]), pend[c], txRdyB[c]);
        else       setTx(c, cur[c], pend[c], txRdyB[c]);
      end
      #3;
      for (int c = 3; c < 5; c++) firstS[c] = txP(c);
      #7;
      for (int c = 0; c < 3; c++) setRxPins(c, split(c, cur[c]) >> 48);
      #3;
      for (int c = 0; c < 5; c++) begin
        logic v;
        logic [95:0] ob;
        bit accepted;
        if (c < 3) begin v = outV(c); ob = outB(c); end
        else begin v = txV(c); ob = join2(c, firstS[c], txP(c)); end
        // R6: a beat taken at the last edge is on the output now
        if (justAcc[c]) chk("R6 latency", {v, ob}, {1'b1, accBeat[c]});
        // R8: stalled output unchanged
        if (prevStall[c]) chk("R8 hold", {v, ob}, {1'b1, prevOut[c]});
        if (v && txRdyB[c]) begin
          qPop(c, e, ok);
          chk("R8 beat expected", ok, 1);
          chk(mapReq(c), ob, e);
        end
        prevStall[c] = v && !txRdyB[c];
        prevOut[c] = ob;
        // R7: upstream ready tracks slice state and downstream ready
        got = (c < 3) ? rxRdy(c) : txInRdy(c);
        chk("R7 ready", got, (!v || txRdyB[c]));
        accepted = pend[c] && got[0];
        justAcc[c] = accepted;
        if (accepted) begin
          qPush(c, cur[c]); accBeat[c] = cur[c]; pend[c] = 0;
        end
      end
    end
    @(posedge clk); #5;
    for (int c = 0; c < 5; c++) begin
      chk("R8 no beat left behind", qSize(c), 0);
      chk("R8 nothing pending", pend[c], 0);
    end
    chk("R7 drained", {awOutValid, wOutValid, arOutValid, rValid, bValid}, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule